// File: doc/BRIEF.md
# Commit-Point Exception Controller

This block steers traps in a five-stage in-order pipeline. Any of four stages can flag a fault against the instruction it holds:
- fetch can flag a bad instruction address;
- decode can flag an unknown opcode;
- execute can flag an arithmetic overflow;
- memory can flag a bad data address.

A flag does not act where it is raised. Each stage register holds a valid bit, a PC and a pending fault with its code, and that record moves down the pipe with the instruction. The block decides whether to trap only when the instruction sits in the memory stage, which is the commit point.

At commit, a pending fault or an asserted external interrupt line causes a trap. The trap does four things:
- it records a cause code and the trapping instruction's PC;
- it blocks the instruction's memory write and register writeback;
- it turns every younger instruction into a bubble, including the one being fetched in that cycle;
- it points fetch at a single fixed handler address.

Instructions that commit without a trap pass into a writeback register one cycle later.

Top module: `exc_commit_ctrl`

## Requirements
- R1: While reset is held, every stage valid, `wb_valid_o`, `take_o`, `cause_o` and `epc_o` read zero.
- R2: An instruction accepted on `if_valid_i` reaches the memory stage three clock edges later. `take_o` is never high unless the memory stage holds a valid instruction, so a fault raised in an earlier stage has no effect before commit.
- R3: Cause codes are 0 for an interrupt, 1 for a fetch address fault, 2 for an illegal opcode, 3 for an overflow and 4 for a data address fault.
- R4: When one instruction collects faults in several stages, the code from the earliest stage is the one recorded.
- R5: `irq_i` high while the memory stage holds a valid instruction forces a trap with cause 0, whatever faults are pending. `irq_i` has no effect while the memory stage is empty.
- R6: On the clock edge that ends a trap cycle, `cause_o` and `epc_o` take the trap's code and the committing instruction's PC. At all other times they hold their values.
- R7: In the cycle after a trap, the decode, execute and memory stages are empty, and the instruction fetched during the trap cycle is discarded.
- R8: During a trap cycle `mem_wr_ok_o` is low, and no writeback follows for the trapping instruction.
- R9: `redirect_pc_o` always carries the parameter `HANDLER_PC`. `take_o` is the signal that tells fetch to use it.
- R10: An instruction that commits without a trap asserts `mem_wr_ok_o` at commit. It appears on `wb_valid_o`/`wb_pc_o` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_valid_i | input | 1 | Fetched instruction entering decode |
| if_pc_i | input | PCW | PC of fetched instruction |
| if_pc_fault_i | input | 1 | Fetch address fault for that instruction |
| id_illegal_i | input | 1 | Decode stage: illegal opcode |
| ex_ovf_i | input | 1 | Execute stage: arithmetic overflow |
| mem_addr_fault_i | input | 1 | Memory stage: data address fault |
| irq_i | input | 1 | External interrupt request |
| take_o | output | 1 | Trap taken at commit this cycle |
| redirect_pc_o | output | PCW | Handler address for fetch |
| mem_wr_ok_o | output | 1 | Committing instruction may write memory |
| cause_o | output | 3 | Cause register |
| epc_o | output | PCW | Trap PC register |
| d_valid_o | output | 1 | Decode stage occupied |
| e_valid_o | output | 1 | Execute stage occupied |
| m_valid_o | output | 1 | Memory stage occupied |
| wb_valid_o | output | 1 | Writeback of a committed instruction |
| wb_pc_o | output | PCW | PC of the instruction in writeback |

## Verification
Timing follows from the stage count. A fetch-stage fault is applied together with its instruction, and each later-stage fault is applied one cycle after the previous stage's, so the fault set is complete three cycles after the fetch. `take_o`, `mem_wr_ok_o` and the redirect are combinational in that commit cycle. The cause, trap PC, bubbled stages and writeback are due one edge later.

The bench drives inputs on the falling edge and samples 1 ns later. It sweeps all sixteen fault combinations, each with and without an interrupt. Behind every swept instruction it feeds three clean younger instructions, then counts writebacks over the next four cycles to confirm whether the younger instructions were killed or drained normally.

// File: rtl/exc_commit_ctrl.sv
module exc_commit_ctrl #(
  parameter int PCW = 32,
  parameter logic [PCW-1:0] HANDLER_PC = PCW'(32'h0000_0180)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           if_valid_i,
  input  logic [PCW-1:0] if_pc_i,
  input  logic           if_pc_fault_i,
  input  logic           id_illegal_i,
  input  logic           ex_ovf_i,
  input  logic           mem_addr_fault_i,
  input  logic           irq_i,
  output logic           take_o,
  output logic [PCW-1:0] redirect_pc_o,
  output logic           mem_wr_ok_o,
  output logic [2:0]     cause_o,
  output logic [PCW-1:0] epc_o,
  output logic           d_valid_o,
  output logic           e_valid_o,
  output logic           m_valid_o,
  output logic           wb_valid_o,
  output logic [PCW-1:0] wb_pc_o
);
  localparam logic [2:0] C_IRQ = 3'd0;
  localparam logic [2:0] C_PC  = 3'd1;
  localparam logic [2:0] C_ILL = 3'd2;
  localparam logic [2:0] C_OVF = 3'd3;
  localparam logic [2:0] C_DAT = 3'd4;

  logic           d_v, e_v, m_v;
  logic [PCW-1:0] d_pc, e_pc, m_pc;
  logic           d_x, e_x, m_x;
  logic [2:0]     d_c, e_c, m_c;

  logic       d_xn, e_xn, m_xn, take;
  logic [2:0] d_cn, e_cn, m_cn, trap_code;

  assign d_xn = d_x | id_illegal_i;
  assign d_cn = d_x ? d_c : C_ILL;
  assign e_xn = e_x | ex_ovf_i;
  assign e_cn = e_x ? e_c : C_OVF;
  assign m_xn = m_x | mem_addr_fault_i;
  assign m_cn = m_x ? m_c : C_DAT;

  assign take      = m_v & (m_xn | irq_i);
  assign trap_code = irq_i ? C_IRQ : m_cn;

  assign take_o        = take;
  assign redirect_pc_o = HANDLER_PC;
  assign mem_wr_ok_o   = m_v & ~take;
  assign d_valid_o     = d_v;
  assign e_valid_o     = e_v;
  assign m_valid_o     = m_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_v <= 1'b0; e_v <= 1'b0; m_v <= 1'b0;
      d_pc <= '0;  e_pc <= '0;  m_pc <= '0;
      d_x <= 1'b0; e_x <= 1'b0; m_x <= 1'b0;
      d_c <= C_IRQ; e_c <= C_IRQ; m_c <= C_IRQ;
      wb_valid_o <= 1'b0;
      wb_pc_o    <= '0;
      cause_o    <= C_IRQ;
      epc_o      <= '0;
    end else begin
      d_v  <= if_valid_i & ~take;
      d_pc <= if_pc_i;
      d_x  <= if_pc_fault_i;
      d_c  <= C_PC;

      e_v  <= d_v & ~take;
      e_pc <= d_pc;
      e_x  <= d_xn;
      e_c  <= d_cn;

      m_v  <= e_v & ~take;
      m_pc <= e_pc;
      m_x  <= e_xn;
      m_c  <= e_cn;

      wb_valid_o <= m_v & ~take;
      wb_pc_o    <= m_pc;

      if (take) begin
        cause_o <= trap_code;
        epc_o   <= m_pc;
      end
    end
  end
endmodule

module exc_commit_ctrl_chk #(
  parameter int PCW = 32,
  parameter logic [PCW-1:0] HANDLER_PC = PCW'(32'h0000_0180)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           irq_i,
  input logic           take_o,
  input logic [PCW-1:0] redirect_pc_o,
  input logic           mem_wr_ok_o,
  input logic [2:0]     cause_o,
  input logic [PCW-1:0] epc_o,
  input logic           d_valid_o,
  input logic           e_valid_o,
  input logic           m_valid_o,
  input logic           wb_valid_o
);
  assert_take_at_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> m_valid_o);
  assert_irq_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && irq_i) |=> cause_o == 3'd0);
  assert_irq_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_i && m_valid_o) |-> take_o);
  assert_regs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |=> ($stable(cause_o) && $stable(epc_o)));
  assert_kill_younger_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> (!d_valid_o && !e_valid_o && !m_valid_o));
  assert_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !mem_wr_ok_o);
  assert_no_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !wb_valid_o);
  assert_clean_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_ok_o |=> wb_valid_o);

  always_comb begin
    if (rst_n) begin
      assert_handler_R9: assert (redirect_pc_o == HANDLER_PC);
    end
  end
endmodule

bind exc_commit_ctrl exc_commit_ctrl_chk #(.PCW(PCW), .HANDLER_PC(HANDLER_PC)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .take_o(take_o),
  .redirect_pc_o(redirect_pc_o), .mem_wr_ok_o(mem_wr_ok_o), .cause_o(cause_o),
  .epc_o(epc_o), .d_valid_o(d_valid_o), .e_valid_o(e_valid_o),
  .m_valid_o(m_valid_o), .wb_valid_o(wb_valid_o)
);

// File: tb/exc_commit_ctrl_tb.sv
`timescale 1ns/1ps
module exc_commit_ctrl_tb;
  localparam int PCW = 32;
  localparam logic [PCW-1:0] HPC = 32'h0000_0180;

  logic clk = 1'b0, rst_n = 1'b0;
  logic if_valid_i = 0, if_pc_fault_i = 0, id_illegal_i = 0, ex_ovf_i = 0;
  logic mem_addr_fault_i = 0, irq_i = 0;
  logic [PCW-1:0] if_pc_i = '0;
  logic take_o, mem_wr_ok_o, d_valid_o, e_valid_o, m_valid_o, wb_valid_o;
  logic [PCW-1:0] redirect_pc_o, epc_o, wb_pc_o;
  logic [2:0] cause_o;

  int nvec = 0, nfail = 0, vec = 0;
  bit done = 0;
  logic [2:0] exp_cause = 3'd0;
  logic [PCW-1:0] exp_epc = '0;

  always #2 clk = ~clk;

  exc_commit_ctrl #(.PCW(PCW), .HANDLER_PC(HPC)) u_dut (
    .clk(clk), .rst_n(rst_n), .if_valid_i(if_valid_i), .if_pc_i(if_pc_i),
    .if_pc_fault_i(if_pc_fault_i), .id_illegal_i(id_illegal_i), .ex_ovf_i(ex_ovf_i),
    .mem_addr_fault_i(mem_addr_fault_i), .irq_i(irq_i), .take_o(take_o),
    .redirect_pc_o(redirect_pc_o), .mem_wr_ok_o(mem_wr_ok_o), .cause_o(cause_o),
    .epc_o(epc_o), .d_valid_o(d_valid_o), .e_valid_o(e_valid_o), .m_valid_o(m_valid_o),
    .wb_valid_o(wb_valid_o), .wb_pc_o(wb_pc_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_one(input logic [3:0] f, input logic irq);
    logic [PCW-1:0] pc;
    logic tk;
    logic [2:0] code;
    string creq;
    int wbcnt;
    pc   = 32'h1000 + vec * 32;
    vec++;
    tk   = (|f) | irq;
    code = irq ? 3'd0 : f[0] ? 3'd1 : f[1] ? 3'd2 : f[2] ? 3'd3 : 3'd4;
    creq = irq ? "R5 cause" : ($countones(f) > 1) ? "R4 cause" : "R3 cause";

    @(negedge clk);
    if_valid_i = 1; if_pc_i = pc; if_pc_fault_i = f[0];
    #1 chk("R2 no trap before commit", take_o, 0);
    @(negedge clk);
    if_pc_i = pc + 4; if_pc_fault_i = 0; id_illegal_i = f[1];
    #1 chk("R2 no trap before commit", take_o, 0);
    @(negedge clk);
    if_pc_i = pc + 8; id_illegal_i = 0; ex_ovf_i = f[2];
    #1 chk("R2 no trap before commit", take_o, 0);
    @(negedge clk);
    if_pc_i = pc + 12; ex_ovf_i = 0; mem_addr_fault_i = f[3]; irq_i = irq;
    #1;
    chk("R2 instruction at commit", m_valid_o, 1);
    chk(irq ? "R5 trap decision" : "R2 trap decision", take_o, tk);
    chk("R8 memory write gate", mem_wr_ok_o, !tk);
    chk("R9 handler pc", redirect_pc_o, HPC);
    @(negedge clk);
    if_valid_i = 0; if_pc_i = '0; mem_addr_fault_i = 0; irq_i = 0;
    #1;
    if (tk) begin exp_cause = code; exp_epc = pc; end
    chk(creq, cause_o, exp_cause);
    chk("R6 trap pc", epc_o, exp_epc);
    chk("R7 decode bubble", d_valid_o, !tk);
    chk("R7 execute bubble", e_valid_o, !tk);
    chk("R7 memory bubble", m_valid_o, !tk);
    chk(tk ? "R8 writeback blocked" : "R10 writeback", wb_valid_o, !tk);
    if (!tk) chk("R10 writeback pc", wb_pc_o, pc);
    wbcnt = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      if (wb_valid_o) wbcnt++;
    end
    chk("R7 younger kill count", wbcnt, tk ? 0 : 3);
    chk("R6 cause held", cause_o, exp_cause);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    #1;
    chk("R1 reset valids", {d_valid_o, e_valid_o, m_valid_o, wb_valid_o}, 0);
    chk("R1 reset take", take_o, 0);
    chk("R1 reset cause", cause_o, 0);
    chk("R1 reset epc", epc_o, 0);
    @(negedge clk);
    rst_n = 1;
    irq_i = 1;
    for (int k = 0; k < 3; k++) begin
      #1 chk("R5 irq ignored on empty commit", take_o, 0);
      @(negedge clk);
    end
    irq_i = 0;
    #1 chk("R5 cause untouched", cause_o, 0);
    for (int i = 0; i < 2; i++)
      for (int p = 0; p < 16; p++)
        run_one(4'(p), i[0]);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule